// File: doc/BRIEF.md
# Dual-Rail Reset Controller with Control Register Bank

This block makes the internal reset for a device that has no reset pin. Each of two supply rails gives it a "rail good" level, already compared against a threshold. While either level is low, reset is asserted at once. When both are high, reset stays asserted for a further counted extension. A drop of either rail starts the whole sequence again. Each rail level also passes through its own two-flop release stage, so reset falls in step with the clock and rises without waiting for a clock edge.

The block also holds a small bank of 16-bit control registers behind a single-cycle write/read port. While reset is active, the bank is held at its default values, writes are dropped and reads return zero. When reset is not active, a write of any data to address 0 reloads every register with its default value. Address 0 has no storage of its own. This software reset does not touch the reset output or the extension counter.

Top module: `rail_reset_ctrl`

## Requirements
- R1: `rst_o` is 1 whenever `rail_a_good_i` or `rail_b_good_i` is 0, and it rises without waiting for a clock edge.
- R2: Suppose both rail inputs go high between clock edges. `rst_o` is still 1 after the first EXT_CYCLES+1 rising edges and is 0 after edge EXT_CYCLES+2. The default EXT_CYCLES is 2500, which is 50 µs at 50 MHz.
- R3: A drop of either rail during the extension sets `rst_o` again. When both rails are high once more, the full R2 count is needed before release.
- R4: While reset is active, and once it ends, register i (1 ≤ i < NUM_REGS) holds the default value 16'hC000 | i until it is written.
- R5: A write issued while `rst_o` is 1 has no effect on any register.
- R6: While `rst_o` is 1, `rdata_o` is 0 and reads return 0.
- R7: Suppose `rst_o` is 0 and `we_i` is set with an address in 1..NUM_REGS-1. That register takes `wdata_i` at the clock edge. A read (`re_i` for one cycle) shows the register on `rdata_o` after that edge.
- R8: Suppose `rst_o` is 0 and a write of any data goes to address 0. At that edge every register returns to its default value. A read of address 0 returns 0.
- R9: Addresses at or above NUM_REGS read as 0, and writes to them are dropped.
- R10: A write to address 0 leaves `rst_o` at 0 and does not restart the extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rail_a_good_i | input | 1 | Rail A above threshold, active high |
| rail_b_good_i | input | 1 | Rail B above threshold, active high |
| we_i | input | 1 | Write strobe, one cycle |
| re_i | input | 1 | Read strobe, one cycle |
| addr_i | input | 8 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| rst_o | output | 1 | Internal reset, active high |

## Verification
The hardest case to reach from the ports is a rail that drops partway through the extension and then recovers. To catch it, a release that is too early or too late must be measured against the second rise, not the first. The stimulus raises both rails and waits half the extension. It then drops one rail for a few cycles, brings it back, and samples `rst_o` on the exact edge count after the second rise. A read of a written register after that release shows that the rail drop also reloaded the bank.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] DEF_BASE = 16'hC000;

  function automatic logic [DATA_W-1:0] reg_default(int idx);
    return DEF_BASE | DATA_W'(idx);
  endfunction
endpackage

// File: rtl/rrc_sync.sv
// Release synchronizer: clears at once, sets after STAGES edges
module rrc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rrc_ext_timer.sv
module rrc_ext_timer #(
  parameter int EXT_CYCLES = 2500
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic good_i,
  output logic rst_o
);
  localparam int CW = $clog2(EXT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(EXT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else if (!good_i) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else if (cnt_q == LAST) begin
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_o = rst_q;
endmodule

// File: rtl/rrc_bank.sv
module rrc_bank
  import rrc_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              hold_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              in_range;
  logic [IW-1:0]     idx;
  logic              soft_rst;
  logic [DATA_W-1:0] rdata_q;

  assign in_range = (int'(addr_i) < NUM_REGS);
  assign idx      = IW'(addr_i);
  assign soft_rst = we_i && (addr_i == '0);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;  // address 0: command only
    end else begin : g_store
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni)                 regs[g] <= reg_default(g);
        else if (hold_i || soft_rst)  regs[g] <= reg_default(g);
        else if (we_i && in_range && idx == IW'(g))
                                      regs[g] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)    rdata_q <= '0;
    else if (hold_i) rdata_q <= '0;
    else if (re_i)   rdata_q <= in_range ? regs[idx] : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rail_reset_ctrl.sv
module rail_reset_ctrl
  import rrc_pkg::*;
#(
  parameter int EXT_CYCLES = 2500,
  parameter int NUM_REGS   = 8,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk_i,
  input  logic              rail_a_good_i,
  input  logic              rail_b_good_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_o
);
  localparam int NRAIL = 2;

  logic [NRAIL-1:0] rail_raw;
  logic [NRAIL-1:0] rail_sync;
  logic             por_n;
  logic             ext_rst;

  assign rail_raw = {rail_b_good_i, rail_a_good_i};
  assign por_n    = &rail_raw;

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    rrc_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk_i   (clk_i),
      .arst_ni (rail_raw[r]),
      .q_o     (rail_sync[r])
    );
  end

  rrc_ext_timer #(.EXT_CYCLES(EXT_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .arst_ni (por_n),
    .good_i  (&rail_sync),
    .rst_o   (ext_rst)
  );

  rrc_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i   (clk_i),
    .arst_ni (por_n),
    .hold_i  (ext_rst),
    .we_i    (we_i),
    .re_i    (re_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  assign rst_o = ext_rst;
endmodule

// File: rtl/rail_reset_ctrl_chk.sv
module rail_reset_ctrl_chk #(
  parameter int EXT_CYCLES = 2500
) (
  input logic        clk_i,
  input logic        rail_a_good_i,
  input logic        rail_b_good_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [15:0] rdata_o,
  input logic        rst_o
);
  localparam int CW = $clog2(EXT_CYCLES + 3) + 1;
  localparam logic [CW-1:0] REL = CW'(EXT_CYCLES + 2);

  logic          good_both;
  logic [CW-1:0] up_cnt;

  assign good_both = rail_a_good_i && rail_b_good_i;

  // edges seen since both rails last went good, saturating
  always_ff @(posedge clk_i or negedge good_both) begin
    if (!good_both)       up_cnt <= '0;
    else if (up_cnt < REL) up_cnt <= up_cnt + 1'b1;
  end

  a_r1_rst_when_rail_low: assert property (@(posedge clk_i)
    !good_both |-> rst_o);

  a_r2_no_early_release: assert property (@(posedge clk_i) disable iff (!good_both)
    !rst_o |-> (up_cnt >= REL));

  a_r3_no_late_release: assert property (@(posedge clk_i) disable iff (!good_both)
    (up_cnt >= REL) |-> !rst_o);

  a_r6_read_zero_in_reset: assert property (@(posedge clk_i) disable iff (!good_both)
    rst_o |=> (rdata_o == '0));

  a_r10_soft_keeps_rst: assert property (@(posedge clk_i) disable iff (!good_both)
    (we_i && addr_i == '0 && !rst_o) |=> !rst_o);
endmodule

bind rail_reset_ctrl rail_reset_ctrl_chk #(.EXT_CYCLES(EXT_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rail_a_good_i (rail_a_good_i),
  .rail_b_good_i (rail_b_good_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .rdata_o       (rdata_o),
  .rst_o         (rst_o)
);

// File: tb/sim_rail_reset_ctrl.sv
`timescale 1ns/1ps
module sim_rail_reset_ctrl;
  localparam int EXT = 40;
  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        ra = 1'b1, rb = 1'b1;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        re_seen = 1'b0;

  always #10 clk = ~clk;

  rail_reset_ctrl #(.EXT_CYCLES(EXT), .NUM_REGS(NREG)) u0 (
    .clk_i(clk), .rail_a_good_i(ra), .rail_b_good_i(rb),
    .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rst_o(rst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(int i);
    return 16'hC000 | 16'(i);
  endfunction

  // monitor: compare read data one edge after the strobe
  always @(posedge clk) re_seen <= re;
  always @(negedge clk) begin
    if (re_seen && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rdata == e, t, rdata, e);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    re = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic release_check(input string t);
    repeat (EXT + 1) @(posedge clk);
    @(negedge clk);
    check(rst == 1'b1, t, rst, 1);
    @(posedge clk);
    @(negedge clk);
    check(rst == 1'b0, t, rst, 0);
  endtask

  initial begin
    #1 ra = 1'b0; rb = 1'b0;
    #1 check(rst == 1'b1, "R1", rst, 1);
    rd(8'd1, 16'h0000, "R6");
    wr(8'd1, 16'h5555);                    // R5: dropped
    // both rails up
    @(negedge clk); ra = 1'b1; rb = 1'b1;
    release_check("R2");
    rd(8'd1, dflt(1), "R5");
    rd(8'd5, dflt(5), "R4");
    rd(8'd0, 16'h0000, "R8");
    rd(8'(NREG), 16'h0000, "R9");
    wr(8'd1, 16'hABCD);
    wr(8'd3, 16'h1234);
    wr(8'(NREG + 1), 16'h7777);
    rd(8'd1, 16'hABCD, "R7");
    rd(8'd3, 16'h1234, "R7");
    rd(8'(NREG + 1), 16'h0000, "R9");
    wr(8'd0, 16'h0000);                    // software reset
    check(rst == 1'b0, "R10", rst, 0);
    repeat (EXT + 4) @(negedge clk);
    check(rst == 1'b0, "R10", rst, 0);
    rd(8'd1, dflt(1), "R8");
    rd(8'd3, dflt(3), "R8");
    wr(8'd2, 16'h0F0F);
    rd(8'd2, 16'h0F0F, "R7");
    // rail drop, then drop during extension
    @(negedge clk); ra = 1'b0;
    #1 check(rst == 1'b1, "R1", rst, 1);
    rd(8'd2, 16'h0000, "R6");
    @(negedge clk); ra = 1'b1;
    repeat (EXT / 2) @(negedge clk);
    check(rst == 1'b1, "R3", rst, 1);
    rb = 1'b0;
    repeat (3) @(negedge clk);
    rb = 1'b1;
    release_check("R3");
    rd(8'd2, dflt(2), "R4");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule